// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Sequencer

This controller sits in front of an SRAM array that has a shadow nonvolatile copy. It decides when the array is copied into the nonvolatile cells (store) and when the nonvolatile cells are copied back into the array (recall). The copy hardware, the supply comparator and the array are outside the block. They are seen only as a supply-good level, a start pulse with a direction bit, and the SRAM access strobes the controller watches.

A store can come from three sources: the supply dropping below its switch level, a sufficiently long low pulse on a hardware store input, or a software command. A recall can come from supply rise or from a software command. A software command is six qualified reads to a fixed address list. A store is skipped when the array has not been written since the last completed copy. While an operation runs, the block holds an active-low busy output and an I/O lockout output. Every duration is a parameter counted in clock cycles.

Top module: `nvsram_seq`

## Requirements
- R1: After reset, and whenever the supply is absent, the block is powered down: io_lock=1, busy_n=1, xfer_go=0. If pwr_ok is sampled high in that state, a recall runs for T_PWRUP_RCL cycles starting on the next cycle, with busy_n=0 and io_lock=1. The block then goes idle (busy_n=1, io_lock=0).
- R2: In idle, a software command is six consecutive qualified reads (mem_ce=1, mem_we=0). The first five addresses are 0x1A5, 0x2C3, 0x0F0, 0x3E1, 0x14B, and the sixth is 0x2D7 for store or 0x36C for recall. Cycles with mem_ce=0 may fall between them. After the sixth read, a processing phase of T_SWPROC cycles follows with busy_n=0 and io_lock=1.
- R3: A write (mem_ce=1, mem_we=1) or a read to an unexpected address abandons a partial command. A read of 0x1A5 that breaks the order counts as step one of a new attempt.
- R4: A store lasts T_STORE cycles with busy_n=0 and io_lock=1.
- R5: A software recall lasts T_RECALL cycles with busy_n=0 and io_lock=1.
- R6: If no write has been accepted since the last completed store or recall, a requested store is skipped: no xfer_go, and the block returns to idle or powers down at once.
- R7: A write sets the dirty condition only while io_lock=0, and that includes the hardware grace window. Writes made while io_lock=1 are ignored.
- R8: When hw_store_n is low for HW_MIN_LOW consecutive idle cycles, a grace window of T_GRACE cycles follows with busy_n=0 and io_lock=0, and then a store (subject to R6). A shorter low pulse has no effect.
- R9: pwr_ok low in idle starts a store (subject to R6). After the store, or at once if the store is skipped, the block enters the powered-down state of R1.
- R10: Hardware and software requests and supply drops that arrive while busy_n=0 do not change the running operation. A supply drop is acted on when the operation ends.
- R11: xfer_go is a one-cycle pulse in the first cycle of each copy. xfer_store is 1 for a store and 0 for a recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply above switch level |
| hw_store_n | input | 1 | Hardware store request, active low |
| mem_ce | input | 1 | SRAM access strobe, one cycle per access |
| mem_we | input | 1 | Access is a write |
| mem_addr | input | AW | Access address |
| busy_n | output | 1 | Low while an operation is active |
| io_lock | output | 1 | SRAM I/O locked out |
| xfer_go | output | 1 | Start pulse for the copy engine |
| xfer_store | output | 1 | Copy direction: 1 store, 0 recall |

## Verification
The assertions check four things on every cycle: the start pulse is one cycle wide and only occurs while the block is busy and locked; a store start never happens with a clean array; a write made under lockout never makes the array dirty; and a write made while unlocked always does. Only the bench scenarios can show the exact phase lengths, the command order and abort rules, the pulse-width threshold, the grace window that leaves I/O open, and the deferred handling of a supply drop that arrives mid-operation.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_PURCL,
    ST_IDLE,
    ST_SWPROC,
    ST_GRACE,
    ST_STORE,
    ST_RECALL
  } nvs_state_e;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_STORE,
    CMD_RECALL
  } nvs_cmd_e;

  localparam int unsigned SEQ_LEN = 6;
  localparam int unsigned KEY_W   = 10;

  // Command key: entries 0..4 are the shared prefix, 5 ends a store, 6 ends a recall.
  function automatic logic [KEY_W-1:0] key_addr(input int unsigned idx);
    logic [KEY_W-1:0] v;
    case (idx)
      0:       v = 10'h1A5;
      1:       v = 10'h2C3;
      2:       v = 10'h0F0;
      3:       v = 10'h3E1;
      4:       v = 10'h14B;
      5:       v = 10'h2D7;
      default: v = 10'h36C;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect
  import nvs_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ce,
  input  logic          we,
  input  logic [AW-1:0] addr,
  output nvs_cmd_e      cmd
);

  localparam int unsigned LAST = SEQ_LEN - 1;
  localparam int unsigned IW   = $clog2(SEQ_LEN);

  logic [IW-1:0]   idx_q, idx_nxt;
  logic [LAST-1:0] step_hit;
  logic            hit_store, hit_recall;

  for (genvar k = 0; k < LAST; k++) begin : g_key
    assign step_hit[k] = (addr == AW'(key_addr(k)));
  end

  assign hit_store  = (addr == AW'(key_addr(LAST)));
  assign hit_recall = (addr == AW'(key_addr(LAST + 1)));

  always_comb begin
    idx_nxt = idx_q;
    cmd     = CMD_NONE;
    if (!en) begin
      idx_nxt = '0;
    end else if (ce) begin
      if (we) begin
        idx_nxt = '0;
      end else if (idx_q == IW'(LAST)) begin
        if (hit_store) begin
          cmd     = CMD_STORE;
          idx_nxt = '0;
        end else if (hit_recall) begin
          cmd     = CMD_RECALL;
          idx_nxt = '0;
        end else begin
          idx_nxt = step_hit[0] ? IW'(1) : '0;
        end
      end else if (step_hit[idx_q]) begin
        idx_nxt = IW'(idx_q + 1'b1);
      end else begin
        idx_nxt = step_hit[0] ? IW'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_nxt;
  end

endmodule

// File: rtl/nvs_pulse_qual.sv
module nvs_pulse_qual #(
  parameter int unsigned MIN_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic req_n,
  output logic accept
);

  localparam int unsigned CW = $clog2(MIN_W + 1);
  localparam logic [CW-1:0] TOP = CW'(MIN_W - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;

  assign accept = en && !req_n && (cnt_q == TOP);

  always_comb begin
    if (!en || req_n)      cnt_nxt = '0;
    else if (cnt_q == TOP) cnt_nxt = cnt_q;
    else                   cnt_nxt = CW'(cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q, cnt_nxt;
  logic         tick;

  assign done = (cnt_q == '0);
  assign tick = load || !done;

  always_comb begin
    if (load) cnt_nxt = load_val;
    else      cnt_nxt = W'(cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/nvsram_seq.sv
module nvsram_seq
  import nvs_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned T_PWRUP_RCL = 2000000,
  parameter int unsigned T_STORE     = 1500000,
  parameter int unsigned T_RECALL    = 20000,
  parameter int unsigned T_SWPROC    = 7000,
  parameter int unsigned T_GRACE     = 7000,
  parameter int unsigned HW_MIN_LOW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ok,
  input  logic          hw_store_n,
  input  logic          mem_ce,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_addr,
  output logic          busy_n,
  output logic          io_lock,
  output logic          xfer_go,
  output logic          xfer_store
);

  localparam int unsigned M1    = (T_PWRUP_RCL > T_STORE) ? T_PWRUP_RCL : T_STORE;
  localparam int unsigned M2    = (T_RECALL > T_SWPROC) ? T_RECALL : T_SWPROC;
  localparam int unsigned M3    = (M1 > M2) ? M1 : M2;
  localparam int unsigned T_MAX = (M3 > T_GRACE) ? M3 : T_GRACE;
  localparam int unsigned TW    = $clog2(T_MAX + 1);

  nvs_state_e    state_q, state_nxt;
  nvs_cmd_e      cmd_q, cmd_nxt, sw_cmd;
  logic          dirty_q, dirty_nxt, dirty_eff;
  logic          go_q, go_nxt;
  logic          wr_accept, hw_accept, in_idle;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          copy_done;

  assign in_idle   = (state_q == ST_IDLE);
  assign wr_accept = mem_ce && mem_we && !io_lock;
  assign dirty_eff = dirty_q || wr_accept;

  nvs_seq_detect #(.AW(AW)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (in_idle),
    .ce    (mem_ce),
    .we    (mem_we),
    .addr  (mem_addr),
    .cmd   (sw_cmd)
  );

  nvs_pulse_qual #(.MIN_W(HW_MIN_LOW)) u_hwq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (in_idle),
    .req_n  (hw_store_n),
    .accept (hw_accept)
  );

  nvs_timer #(.W(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  // Next-state logic
  always_comb begin
    state_nxt = state_q;
    cmd_nxt   = cmd_q;
    case (state_q)
      ST_OFF: begin
        if (pwr_ok) state_nxt = ST_PURCL;
      end
      ST_PURCL, ST_STORE, ST_RECALL: begin
        if (tmr_done) state_nxt = pwr_ok ? ST_IDLE : ST_OFF;
      end
      ST_IDLE: begin
        if (!pwr_ok) begin
          state_nxt = dirty_eff ? ST_STORE : ST_OFF;
        end else if (hw_accept) begin
          state_nxt = ST_GRACE;
        end else if (sw_cmd != CMD_NONE) begin
          state_nxt = ST_SWPROC;
          cmd_nxt   = sw_cmd;
        end
      end
      ST_SWPROC: begin
        if (tmr_done) begin
          if (cmd_q == CMD_RECALL) state_nxt = ST_RECALL;
          else                     state_nxt = dirty_eff ? ST_STORE : ST_IDLE;
        end
      end
      ST_GRACE: begin
        if (tmr_done) state_nxt = dirty_eff ? ST_STORE : ST_IDLE;
      end
      default: state_nxt = ST_OFF;
    endcase
  end

  // Phase timer load
  assign tmr_load = (state_nxt != state_q);

  always_comb begin
    case (state_nxt)
      ST_PURCL:  tmr_val = TW'(T_PWRUP_RCL - 1);
      ST_STORE:  tmr_val = TW'(T_STORE - 1);
      ST_RECALL: tmr_val = TW'(T_RECALL - 1);
      ST_SWPROC: tmr_val = TW'(T_SWPROC - 1);
      ST_GRACE:  tmr_val = TW'(T_GRACE - 1);
      default:   tmr_val = '0;
    endcase
  end

  // Dirty tracking and copy start
  assign copy_done = tmr_done &&
                     ((state_q == ST_PURCL) || (state_q == ST_STORE) || (state_q == ST_RECALL));

  always_comb begin
    if (copy_done)      dirty_nxt = 1'b0;
    else if (wr_accept) dirty_nxt = 1'b1;
    else                dirty_nxt = dirty_q;
  end

  assign go_nxt = tmr_load &&
                  ((state_nxt == ST_PURCL) || (state_nxt == ST_STORE) || (state_nxt == ST_RECALL));

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cmd_q   <= CMD_NONE;
      dirty_q <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_nxt;
      cmd_q   <= cmd_nxt;
      dirty_q <= dirty_nxt;
      go_q    <= go_nxt;
    end
  end

  // Outputs
  assign busy_n     = !((state_q == ST_PURCL) || (state_q == ST_SWPROC) || (state_q == ST_GRACE) ||
                        (state_q == ST_STORE) || (state_q == ST_RECALL));
  assign io_lock    = (state_q == ST_OFF) || (state_q == ST_PURCL) || (state_q == ST_SWPROC) ||
                      (state_q == ST_STORE) || (state_q == ST_RECALL);
  assign xfer_go    = go_q;
  assign xfer_store = (state_q == ST_STORE);

endmodule

// File: rtl/nvsram_seq_chk.sv
module nvsram_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_ce,
  input logic mem_we,
  input logic busy_n,
  input logic io_lock,
  input logic xfer_go,
  input logic xfer_store,
  input logic dirty
);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_off_r1: assert (io_lock && busy_n && !xfer_go)
        else $error("reset state wrong");
    end
  end

  p_go_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> !xfer_go);

  p_go_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> (!busy_n && io_lock));

  p_store_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && xfer_store) |-> dirty);

  p_locked_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_lock && !dirty) |=> !dirty);

  p_open_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ce && mem_we && !io_lock) |=> dirty);

endmodule

bind nvsram_seq nvsram_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_ce     (mem_ce),
  .mem_we     (mem_we),
  .busy_n     (busy_n),
  .io_lock    (io_lock),
  .xfer_go    (xfer_go),
  .xfer_store (xfer_store),
  .dirty      (dirty_q)
);

// File: tb/nvsram_seq_tb.sv
module nvsram_seq_tb;

  localparam int AW = 10;
  localparam int PU = 5;
  localparam int ST = 4;
  localparam int RC = 3;
  localparam int SS = 2;
  localparam int GR = 3;
  localparam int HM = 2;

  localparam logic [AW-1:0] K0 = 10'h1A5, K1 = 10'h2C3, K2 = 10'h0F0,
                            K3 = 10'h3E1, K4 = 10'h14B, KS = 10'h2D7, KR = 10'h36C;

  logic clk = 1'b0;
  logic rst_n, pwr_ok, hw_store_n, mem_ce, mem_we;
  logic [AW-1:0] mem_addr;
  logic busy_n, io_lock, xfer_go, xfer_store;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  nvsram_seq #(
    .AW(AW), .T_PWRUP_RCL(PU), .T_STORE(ST), .T_RECALL(RC),
    .T_SWPROC(SS), .T_GRACE(GR), .HW_MIN_LOW(HM)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .hw_store_n(hw_store_n),
    .mem_ce(mem_ce), .mem_we(mem_we), .mem_addr(mem_addr),
    .busy_n(busy_n), .io_lock(io_lock), .xfer_go(xfer_go), .xfer_store(xfer_store)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {busy_n,io_lock,go,store} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Check n cycles of one phase; go is expected only in its first cycle.
  task automatic phase(int n, logic b, logic l, logic go, logic st, string tag);
    for (int i = 0; i < n; i++) begin
      chk(tag, {busy_n, io_lock, xfer_go, xfer_go & xfer_store},
          {b, l, (i == 0) ? go : 1'b0, (i == 0) ? (go & st) : 1'b0});
      step();
    end
  endtask

  task automatic rd(logic [AW-1:0] a);
    mem_ce = 1'b1; mem_we = 1'b0; mem_addr = a;
    step();
    mem_ce = 1'b0;
  endtask

  task automatic wr();
    mem_ce = 1'b1; mem_we = 1'b1; mem_addr = '0;
    step();
    mem_ce = 1'b0; mem_we = 1'b0;
  endtask

  task automatic sw_seq(bit recall, bit gaps);
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: rd(K0);
        1: rd(K1);
        2: rd(K2);
        3: rd(K3);
        4: rd(K4);
        default: rd(recall ? KR : KS);
      endcase
      if (gaps && k < 5) step();
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwr_ok = 1'b0; hw_store_n = 1'b1;
    mem_ce = 1'b0; mem_we = 1'b0; mem_addr = '0;
    step(); step();
    phase(1, 1, 1, 0, 0, "R1 reset state");
    rst_n = 1'b1;
    phase(2, 1, 1, 0, 0, "R1 powered down without supply");

    // R1 power-up recall
    pwr_ok = 1'b1; step();
    phase(PU, 0, 1, 1, 0, "R1/R11 power-up recall");
    phase(1, 1, 0, 0, 0, "R1 idle after recall");

    // R6 clean software store
    sw_seq(0, 0);
    phase(SS, 0, 1, 0, 0, "R2 processing");
    phase(1, 1, 0, 0, 0, "R6 clean store skipped");

    // R4 store with gaps between reads
    wr();
    sw_seq(0, 1);
    phase(SS, 0, 1, 0, 0, "R2 processing with gaps");
    phase(ST, 0, 1, 1, 1, "R4/R11 software store");
    phase(1, 1, 0, 0, 0, "R4 idle after store");

    sw_seq(0, 0);
    phase(SS, 0, 1, 0, 0, "R2 processing");
    phase(1, 1, 0, 0, 0, "R6 dirty cleared by store");

    // R5 software recall
    sw_seq(1, 0);
    phase(SS, 0, 1, 0, 0, "R2 processing recall");
    phase(RC, 0, 1, 1, 0, "R5 software recall");
    phase(1, 1, 0, 0, 0, "R5 idle after recall");

    // R7 write during lockout ignored
    sw_seq(0, 0);
    mem_ce = 1'b1; mem_we = 1'b1;
    phase(1, 0, 1, 0, 0, "R2 processing");
    mem_ce = 1'b0; mem_we = 1'b0;
    phase(SS - 1, 0, 1, 0, 0, "R2 processing");
    phase(1, 1, 0, 0, 0, "R7 locked write ignored");

    // R3 aborts
    wr();
    rd(K0); rd(K1); wr(); rd(K2); rd(K3); rd(K4); rd(KS);
    phase(3, 1, 0, 0, 0, "R3 write aborts sequence");
    rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd(10'h001);
    phase(3, 1, 0, 0, 0, "R3 bad final address");
    rd(K1); rd(K0); rd(K2); rd(K3); rd(K4); rd(KS);
    phase(3, 1, 0, 0, 0, "R3 out of order");
    rd(K0); rd(K1); rd(K0); rd(K1); rd(K2); rd(K3); rd(K4); rd(KS);
    phase(SS, 0, 1, 0, 0, "R3 restart on first key");
    phase(ST, 0, 1, 1, 1, "R3 restart store");
    phase(1, 1, 0, 0, 0, "R3 idle");

    // R8 hardware store pulse width sweep (clean array)
    for (int len = 1; len < HM; len++) begin
      hw_store_n = 1'b0;
      for (int j = 0; j < len; j++) step();
      hw_store_n = 1'b1;
      phase(3, 1, 0, 0, 0, "R8 short pulse ignored");
    end
    hw_store_n = 1'b0; step();
    for (int j = 1; j < HM; j++) phase(1, 1, 0, 0, 0, "R8 counting low cycles");
    hw_store_n = 1'b1;
    phase(GR, 0, 0, 0, 0, "R8 grace window");
    phase(1, 1, 0, 0, 0, "R6 clean hardware store skipped");

    // R8 write inside grace makes the store happen
    hw_store_n = 1'b0; step();
    for (int j = 1; j < HM; j++) phase(1, 1, 0, 0, 0, "R8 counting low cycles");
    hw_store_n = 1'b1;
    mem_ce = 1'b1; mem_we = 1'b1;
    phase(1, 0, 0, 0, 0, "R8 grace open to write");
    mem_ce = 1'b0; mem_we = 1'b0;
    phase(GR - 1, 0, 0, 0, 0, "R8 grace window");
    phase(ST, 0, 1, 1, 1, "R7/R8 store after grace write");
    phase(1, 1, 0, 0, 0, "R8 idle");

    // R10 hardware request while busy ignored
    wr();
    sw_seq(0, 0);
    hw_store_n = 1'b0;
    phase(SS, 0, 1, 0, 0, "R10 processing with hw low");
    phase(1, 0, 1, 1, 1, "R10 store with hw low");
    hw_store_n = 1'b1;
    phase(ST - 1, 0, 1, 0, 0, "R10 store continues");
    phase(3, 1, 0, 0, 0, "R10 hw request while busy ignored");

    // R10 supply drop during recall is deferred
    sw_seq(1, 0);
    pwr_ok = 1'b0;
    phase(SS, 0, 1, 0, 0, "R10 processing during drop");
    phase(RC, 0, 1, 1, 0, "R10 recall completes");
    phase(2, 1, 1, 0, 0, "R10/R9 powered down after op");
    pwr_ok = 1'b1; step();
    phase(PU, 0, 1, 1, 0, "R1 power-up recall");
    phase(1, 1, 0, 0, 0, "R1 idle");

    // R9 automatic store on supply drop
    wr();
    pwr_ok = 1'b0; step();
    phase(ST, 0, 1, 1, 1, "R9 automatic store");
    phase(2, 1, 1, 0, 0, "R9 powered down");
    pwr_ok = 1'b1; step();
    phase(PU, 0, 1, 1, 0, "R1 power-up recall");
    phase(1, 1, 0, 0, 0, "R1 idle");
    pwr_ok = 1'b0; step();
    phase(2, 1, 1, 0, 0, "R9/R6 clean drop powers down");
    wr();
    phase(1, 1, 1, 0, 0, "R7 write while powered down");
    pwr_ok = 1'b1; step();
    phase(PU, 0, 1, 1, 0, "R1 power-up recall");
    phase(1, 1, 0, 0, 0, "R1 idle");

    done = 1;
    summary();
    $finish;
  end

endmodule